// File: doc/BRIEF.md
# Serial Training Pattern Detector

This block watches one receive lane, one bit at a time, and reports when the lane carries either of two square-wave training sequences. The short sequence repeats every 16 bits as a run of eight ones followed by eight zeros. The long sequence repeats every 32 bits as sixteen ones followed by sixteen zeros. Each bit is taken only when its valid strobe is high. The bit positions just before each level change can be excluded from the comparison, because those are the positions most affected by jitter or a slow transition. Each sequence has its own 2-bit tolerance code that sets how many such positions are excluded.

All incoming bits go into one shared history register. On every valid bit, each sequence detector compares the newest 16 or 32 bits, including the bit now arriving, against its masked template. This comparison is made at every bit offset until a first hit occurs. After that, the detector compares only once per period, at the same phase as the first hit. It raises its found flag once a programmable number of consecutive aligned periods have matched. A single aligned mismatch drops the flag and sends the detector back to searching.

Each detector runs its own state machine with three states. In HUNT it compares at every offset. In TRACK it counts periods after a first hit. In LOCK the found flag is high. The transitions are:
- HUNT to TRACK on a hit when the threshold is 2 or more.
- HUNT to LOCK on a hit when the threshold is 0 or 1.
- TRACK stays in TRACK on an aligned hit below the threshold.
- TRACK to LOCK on the aligned hit that reaches the threshold.
- LOCK stays in LOCK on an aligned hit.
- TRACK or LOCK to HUNT on an aligned miss.

Top module: `trn_pat_detect`

## Requirements
- R1: For the short pattern, a window of the 16 most recent valid bits matches when, from oldest to newest, its first 8 bits are 1 and its last 8 bits are 0, with excluded positions ignored.
- R2: For the long pattern, a window of the 32 most recent valid bits matches when, from oldest to newest, its first 16 bits are 1 and its last 16 bits are 0, with excluded positions ignored.
- R3: Tolerance code 2'b01 excludes the final bit of the ones half and the final bit of the zeros half.
- R4: Tolerance code 2'b00 excludes the final two bits of each half.
- R5: Tolerance codes 2'b10 and 2'b11 both exclude the final four bits of each half.
- R6: With a threshold N of 2 or more, the found flag rises in the cycle after the valid bit that completes the N-th consecutive aligned matching period. Before that bit, the flag is low.
- R7: While tracking or locked, a single aligned period that mismatches clears the found flag in the cycle after that period's last bit, and the run count restarts.
- R8: Cycles with the valid strobe low have no effect: the bit value is ignored and both found flags hold.
- R9: A threshold of 0 or 1 raises the found flag in the cycle after the first matching window.
- R10: While reset is held, both flags are low. After reset, the bit history reads as all zeros.
- R11: A pattern is found at any bit alignment relative to the start of the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Serial receive bit |
| rx_vld | input | 1 | High when rx_bit carries a new bit |
| a_len_code | input | 2 | Tolerance code for the 16-bit pattern |
| b_len_code | input | 2 | Tolerance code for the 32-bit pattern |
| a_hyst | input | HYST_W | Consecutive matching periods needed for the 16-bit pattern |
| b_hyst | input | HYST_W | Consecutive matching periods needed for the 32-bit pattern |
| a_found | output | 1 | 16-bit pattern found |
| b_found | output | 1 | 32-bit pattern found |

## Verification
The assertions assume three things. First, the tolerance codes and thresholds change only between test phases. Second, each found flag can change only on a cycle that carries a valid bit. Third, a rising flag always follows a hit and a falling flag always follows a miss. The stimulus keeps the configuration fixed within each phase. Every phase begins with at least 64 zero bits, which return both detectors to HUNT with a clean history. Idle cycles drive deliberately misleading bit values to show that those values are ignored.

// File: rtl/trn_pat_pkg.sv
`timescale 1ns/1ps
package trn_pat_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TRACK = 2'd1,
        ST_LOCK  = 2'd2
    } lock_st_e;

    localparam logic [1:0] TOL_TWO = 2'b00;
    localparam logic [1:0] TOL_ONE = 2'b01;
endpackage

// File: rtl/trn_shift_win.sv
`timescale 1ns/1ps
module trn_shift_win #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic         din,
    output logic [W-1:0] win_next
);
    logic [W-1:0] hist_q;

    // Bit 0 is the newest bit. The bit now arriving is included.
    assign win_next = {hist_q[W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist_q <= '0;
        else if (vld) hist_q <= win_next;
    end
endmodule

// File: rtl/trn_pat_match.sv
`timescale 1ns/1ps
module trn_pat_match
    import trn_pat_pkg::*;
#(
    parameter int PER = 16
) (
    input  logic [PER-1:0] win,
    input  logic [1:0]     len_code,
    output logic           hit
);
    localparam int HALF = PER / 2;

    logic [PER-1:0] err;

    for (genvar i = 0; i < PER; i++) begin : g_bit
        localparam int   T   = PER - 1 - i;      // age order, 0 = oldest
        localparam int   POS = T % HALF;
        localparam logic EXP = (T < HALF);
        localparam logic C1  = (POS < HALF - 1);
        localparam logic C2  = (POS < HALF - 2);
        localparam logic C4  = (POS < HALF - 4);
        logic care;
        always_comb begin
            if (len_code == TOL_ONE)      care = C1;
            else if (len_code == TOL_TWO) care = C2;
            else                          care = C4;
        end
        assign err[i] = care & (win[i] ^ EXP);
    end

    assign hit = ~|err;
endmodule

// File: rtl/trn_lock_fsm.sv
`timescale 1ns/1ps
module trn_lock_fsm
    import trn_pat_pkg::*;
#(
    parameter int PER    = 16,
    parameter int HYST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic              hit,
    input  logic [HYST_W-1:0] hyst,
    output logic              found
);
    localparam int PH_W = $clog2(PER);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);

    lock_st_e          state_q, state_d;
    logic [PH_W-1:0]   phase_q, phase_d;
    logic [HYST_W-1:0] run_q, run_d;
    logic [HYST_W:0]   run_inc;

    assign run_inc = {1'b0, run_q} + 1'b1;

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        run_d   = run_q;
        if (vld) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (hit) begin
                        run_d   = HYST_W'(1);
                        phase_d = '0;
                        state_d = (hyst <= HYST_W'(1)) ? ST_LOCK : ST_TRACK;
                    end
                end
                ST_TRACK, ST_LOCK: begin
                    if (phase_q == PH_LAST) begin
                        phase_d = '0;
                        if (hit) begin
                            if (!(&run_q)) run_d = run_inc[HYST_W-1:0];
                            if (state_q == ST_LOCK || run_inc >= {1'b0, hyst})
                                state_d = ST_LOCK;
                        end else begin
                            run_d   = '0;
                            state_d = ST_HUNT;
                        end
                    end else begin
                        phase_d = phase_q + 1'b1;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            phase_q <= '0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        found = (state_q == ST_LOCK);
    end
endmodule

// File: rtl/trn_pat_detect.sv
`timescale 1ns/1ps
module trn_pat_detect #(
    parameter int A_PER  = 16,
    parameter int B_PER  = 32,
    parameter int HYST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_vld,
    input  logic [1:0]        a_len_code,
    input  logic [1:0]        b_len_code,
    input  logic [HYST_W-1:0] a_hyst,
    input  logic [HYST_W-1:0] b_hyst,
    output logic              a_found,
    output logic              b_found
);
    localparam int WIN_W = (A_PER > B_PER) ? A_PER : B_PER;

    logic [WIN_W-1:0] win;
    logic             a_hit;
    logic             b_hit;

    trn_shift_win #(.W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .vld(rx_vld), .din(rx_bit), .win_next(win)
    );

    trn_pat_match #(.PER(A_PER)) u_match_a (
        .win(win[A_PER-1:0]), .len_code(a_len_code), .hit(a_hit)
    );

    trn_pat_match #(.PER(B_PER)) u_match_b (
        .win(win[B_PER-1:0]), .len_code(b_len_code), .hit(b_hit)
    );

    trn_lock_fsm #(.PER(A_PER), .HYST_W(HYST_W)) u_fsm_a (
        .clk(clk), .rst_n(rst_n), .vld(rx_vld), .hit(a_hit),
        .hyst(a_hyst), .found(a_found)
    );

    trn_lock_fsm #(.PER(B_PER), .HYST_W(HYST_W)) u_fsm_b (
        .clk(clk), .rst_n(rst_n), .vld(rx_vld), .hit(b_hit),
        .hyst(b_hyst), .found(b_found)
    );
endmodule

// File: rtl/trn_pat_detect_chk.sv
`timescale 1ns/1ps
module trn_pat_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_vld,
    input logic a_hit,
    input logic b_hit,
    input logic a_found,
    input logic b_found
);
    AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> (!a_found && !b_found)); // R10
    AST_A_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rx_vld |=> $stable(a_found)); // R8
    AST_B_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rx_vld |=> $stable(b_found)); // R8
    AST_A_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(a_found) |-> $past(rx_vld && a_hit)); // R6
    AST_B_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(b_found) |-> $past(rx_vld && b_hit)); // R6
    AST_A_FALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n) $fell(a_found) |-> $past(rx_vld && !a_hit)); // R7
    AST_B_FALL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n) $fell(b_found) |-> $past(rx_vld && !b_hit)); // R7
endmodule

bind trn_pat_detect trn_pat_detect_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .a_hit(a_hit), .b_hit(b_hit),
    .a_found(a_found), .b_found(b_found)
);

// File: tb/test_trn_pat_detect.sv
`timescale 1ns/1ps
module test_trn_pat_detect;
    localparam int HW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_bit = 1'b0;
    logic          rx_vld = 1'b0;
    logic [1:0]    a_len_code = 2'b00;
    logic [1:0]    b_len_code = 2'b00;
    logic [HW-1:0] a_hyst = 5'd4;
    logic [HW-1:0] b_hyst = 5'd3;
    logic          a_found;
    logic          b_found;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";

    always #2 clk = ~clk;

    trn_pat_detect #(.A_PER(16), .B_PER(32), .HYST_W(HW)) i_trn_pat_detect (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_vld(rx_vld),
        .a_len_code(a_len_code), .b_len_code(b_len_code),
        .a_hyst(a_hyst), .b_hyst(b_hyst),
        .a_found(a_found), .b_found(b_found)
    );

    // ---------------- behavioural reference ----------------
    bit hist[$];
    int m_st[2];   // 0 hunt, 1 track, 2 lock
    int m_ph[2];
    int m_run[2];

    function automatic bit ref_hit(int per, logic [1:0] code);
        int k;
        int h;
        k = (code == 2'b01) ? 1 : (code == 2'b00) ? 2 : 4;
        h = per / 2;
        for (int t = 0; t < per; t++) begin
            bit b;
            bit e;
            b = hist[32 - per + t];
            e = (t < h);
            if ((t % h) < h - k && b != e) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic ref_step(int ln, int per, bit hit, int thr);
        if (m_st[ln] == 0) begin
            if (hit) begin
                m_run[ln] = 1;
                m_ph[ln]  = 0;
                m_st[ln]  = (thr <= 1) ? 2 : 1;
            end
        end else if (m_ph[ln] == per - 1) begin
            m_ph[ln] = 0;
            if (hit) begin
                if (m_run[ln] < 31) m_run[ln]++;
                if (m_st[ln] == 2 || m_run[ln] >= thr) m_st[ln] = 2;
            end else begin
                m_run[ln] = 0;
                m_st[ln]  = 0;
            end
        end else begin
            m_ph[ln]++;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 32; i++) hist.push_back(1'b0);
            for (int l = 0; l < 2; l++) begin
                m_st[l] = 0; m_ph[l] = 0; m_run[l] = 0;
            end
        end else if (rx_vld) begin
            bit ha;
            bit hb;
            hist.push_back(rx_bit);
            void'(hist.pop_front());
            ha = ref_hit(16, a_len_code);
            hb = ref_hit(32, b_len_code);
            ref_step(0, 16, ha, int'(a_hyst));
            ref_step(1, 32, hb, int'(b_hyst));
        end
    end

    always @(negedge clk) begin
        checks++;
        if (a_found !== (m_st[0] == 2) || b_found !== (m_st[1] == 2)) begin
            errors++;
            $display("FAIL %s model compare: a_found=%b b_found=%b expected %b %b",
                     cur_req, a_found, b_found, m_st[0] == 2, m_st[1] == 2);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic send(logic b);
        rx_bit = b;
        rx_vld = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(int n, logic junk);
        for (int i = 0; i < n; i++) begin
            rx_vld = 1'b0;
            rx_bit = junk ^ i[0];
            @(negedge clk);
        end
    endtask

    task automatic flush();
        for (int i = 0; i < 64; i++) send(1'b0);
    endtask

    task automatic send_a(int nper, int flip);
        for (int p = 0; p < nper; p++)
            for (int i = 0; i < 16; i++) send((i < 8) ^ (i == flip));
    endtask

    task automatic send_b(int nper);
        for (int p = 0; p < nper; p++)
            for (int i = 0; i < 32; i++) send(i < 16);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset a", a_found, 1'b0);
        chk("R10 reset b", b_found, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R6: threshold 4, flag rises exactly at bit 64
        cur_req = "R6";
        flush();
        send_a(3, -1);
        for (int i = 0; i < 15; i++) send(i < 8);
        chk("R6 before 4th period", a_found, 1'b0);
        send(1'b0);
        chk("R1 R6 at 4th period", a_found, 1'b1);

        // R7: one corrupted period drops the flag
        cur_req = "R7";
        send_a(2, -1);
        chk("R7 still locked", a_found, 1'b1);
        send_a(1, 2);
        chk("R7 cleared after bad period", a_found, 1'b0);

        // R3: code 01, bit 6 flipped never matches
        cur_req = "R3";
        a_len_code = 2'b01; a_hyst = 5'd2;
        flush();
        for (int p = 0; p < 6; p++)
            for (int i = 0; i < 16; i++) begin
                send((i < 8) ^ (i == 6));
                if (a_found !== 1'b0) chk("R3 no match code01", a_found, 1'b0);
            end
        chk("R3 end", a_found, 1'b0);

        // R4: code 00 tolerates bit 6
        cur_req = "R4";
        a_len_code = 2'b00;
        flush();
        send_a(6, 6);
        chk("R4 code00 tolerates", a_found, 1'b1);

        // R5: bit 4 flipped, only codes 10/11 tolerate
        cur_req = "R5";
        flush();
        for (int p = 0; p < 6; p++)
            for (int i = 0; i < 16; i++) begin
                send((i < 8) ^ (i == 4));
                if (a_found !== 1'b0) chk("R5 code00 rejects", a_found, 1'b0);
            end
        chk("R5 code00 end", a_found, 1'b0);
        a_len_code = 2'b10;
        flush();
        send_a(6, 4);
        chk("R5 code10 tolerates", a_found, 1'b1);
        a_len_code = 2'b11;
        flush();
        send_a(6, 4);
        chk("R5 code11 tolerates", a_found, 1'b1);

        // R2: long pattern, threshold 3
        cur_req = "R2";
        a_len_code = 2'b00;
        flush();
        send_b(2);
        for (int i = 0; i < 31; i++) send(i < 16);
        chk("R2 before 3rd period", b_found, 1'b0);
        send(1'b0);
        chk("R2 at 3rd period", b_found, 1'b1);

        // R9: threshold 0 / 1 locks on first hit
        cur_req = "R9";
        b_hyst = 5'd0; a_hyst = 5'd1;
        flush();
        for (int i = 0; i < 15; i++) send(i < 8);
        chk("R9 a before first window", a_found, 1'b0);
        send(1'b0);
        chk("R9 a first window", a_found, 1'b1);
        flush();
        for (int i = 0; i < 31; i++) send(i < 16);
        chk("R9 b before first window", b_found, 1'b0);
        send(1'b0);
        chk("R9 b first window", b_found, 1'b1);

        // R8: gaps with junk bits are ignored
        cur_req = "R8";
        a_hyst = 5'd3; b_hyst = 5'd3;
        flush();
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 16; i++) begin
                send(i < 8);
                if (i % 2 == 1) idle(1, !(i < 8));
            end
        chk("R8 lock through gaps", a_found, 1'b1);
        idle(20, 1'b1);
        chk("R8 idle holds lock", a_found, 1'b1);
        flush();
        idle(20, 1'b1);
        chk("R8 idle in hunt", a_found, 1'b0);

        // R11: arbitrary alignment
        cur_req = "R11";
        flush();
        for (int i = 0; i < 5; i++) send(1'b1);
        send_a(5, -1);
        chk("R11 offset lock", a_found, 1'b1);

        idle(4, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule